// File: doc/BRIEF.md
# Multichannel Fault Supervisor Logic

This block is the digital back end of a six-rail voltage supervisor. Analog comparators upstream report, for each rail, whether it sits below its low limit (undervoltage) or above its high limit (overvoltage). Two further auxiliary comparators report whether an extra input is above a fixed level. Everything arrives as bits already in the block's clock domain. Two general-purpose input pins can each be given a mode that changes how faults are treated. One mode hides low-rail faults, used while supplies ramp. Another hides all faults, used while supplies are deliberately pushed beyond tolerance. A third turns the pin into an active-low manual reset.

The block keeps three views of the rail faults. The live status shows faults that are present now. The history holds sticky bits for every fault seen since it was last cleared. The snapshot freezes the first fault pattern seen after power-up or after a manual reset. Three output pins are each driven from a programmable selection of fault and input sources. Each output has its own polarity and its own assertion delay, counted in 100 µs ticks up to 1.6 s. Release of an output is immediate. Each output pin is modelled as an open-drain pull-down enable.

Top module: `fault_supervisor`

## Requirements
- R1: `status_uv[i]` and `status_ov[i]` show the masked undervoltage and overvoltage comparator bits of channel i one clock after the comparator inputs change.
- R2: An input pin in mode 1 (undervoltage disable), held low, masks the undervoltage bits of all channels from status, history, snapshot and outputs. Overvoltage bits still pass.
- R3: An input pin in mode 2 (margin), held low, masks both undervoltage and overvoltage bits of all channels from status, history, snapshot and outputs.
- R4: History bits are set by any unmasked fault. They stay set after the fault goes away and are cleared only by `clear_hist` or by a manual-reset clear. A clear wins over a fault in the same cycle.
- R5: The first cycle with any unmasked fault copies the masked fault pattern into `snap_uv`/`snap_ov` and sets `snap_valid`. Later faults and `clear_hist` leave the snapshot unchanged.
- R6: An input pin in mode 3 (manual reset), held low while `cfg_mr_clear` is 1, clears the history and empties the snapshot (`snap_valid` = 0). The clear has priority over faults. With `cfg_mr_clear` = 0 the pin leaves both untouched.
- R7: `aux_status[i]` equals `aux_cmp[i]` XOR `cfg_aux_pol[i]`, registered one clock after the input changes.
- R8: Each output has a 15-bit source map. Bits 0–5 are channel undervoltage, bits 6–11 channel overvoltage, bits 12–13 auxiliary status and bit 14 manual reset active. The output is requested while any mapped source is set.
- R9: With `cfg_out_pol[k]` = 0, `out_drive_low[k]` is 1 while output k is asserted. With 1, it is 1 while the output is not asserted. After reset no output is asserted.
- R10: An output asserts after its request has been held for D ticks (D from the 14-bit delay field, one tick every TICK_DIV clocks). D = 0 asserts two clocks after the input change. Values above 16000 act as 16000.
- R11: When the request drops, the output deasserts two clocks after the input change, whatever its delay.
- R12: An input pin in mode 0 has no effect on masking, history or snapshot, whatever its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_cmp | input | NCH | Undervoltage comparator bits, 1 = fault |
| ov_cmp | input | NCH | Overvoltage comparator bits, 1 = fault |
| aux_cmp | input | NAUX | Auxiliary comparator bits |
| gpi_n | input | NGPI | General-purpose input pins, active low |
| cfg_gpi_mode | input | 2*NGPI | Mode per input pin: 0 off, 1 UV disable, 2 margin, 3 manual reset |
| cfg_aux_pol | input | NAUX | Inversion per auxiliary comparator |
| cfg_mr_clear | input | 1 | Manual reset clears history and re-arms the snapshot |
| clear_hist | input | 1 | Clear command for the history |
| cfg_out_map | input | NOUT*15 | Source map per output |
| cfg_out_pol | input | NOUT | Polarity per output |
| cfg_out_delay | input | NOUT*14 | Assertion delay per output in ticks |
| status_uv | output | NCH | Live masked undervoltage status |
| status_ov | output | NCH | Live masked overvoltage status |
| aux_status | output | NAUX | Polarity-corrected auxiliary status |
| hist_uv | output | NCH | Sticky undervoltage history |
| hist_ov | output | NCH | Sticky overvoltage history |
| snap_uv | output | NCH | First-fault undervoltage pattern |
| snap_ov | output | NCH | First-fault overvoltage pattern |
| snap_valid | output | 1 | Snapshot holds a capture |
| out_drive_low | output | NOUT | Pull-down enable per output pin |

## Verification
The assertions watch several properties on every cycle. They confirm that an active margin pin leaves the live status empty, and that an active UV-disable pin leaves the undervoltage status empty. They confirm that history bits never fall without a clear, and that a valid snapshot is frozen until a re-arm. They also check that a re-arm empties history and snapshot, that an output never asserts without a request, and that it releases the cycle after its request drops. Only the bench's scenarios can show the rest. These are the capture of the right first pattern, the exact source bit positions and pin polarities, the difference between modes 0 and 3 with the clear enable off, and the delay timing. For the delay timing, the bench checks the assertion window for a short delay and checks that an oversized delay is clamped to 16000 ticks.

// File: rtl/fsv_pkg.sv
package fsv_pkg;

    localparam int unsigned FSV_DLY_W   = 14;
    localparam int unsigned FSV_DLY_MAX = 16000;

    typedef enum logic [1:0] {
        GPI_OFF    = 2'd0,
        GPI_UVDIS  = 2'd1,
        GPI_MARGIN = 2'd2,
        GPI_MRESET = 2'd3
    } gpi_mode_e;

    typedef struct packed {
        logic uv_mask;
        logic all_mask;
        logic mr_act;
    } pin_ctl_t;

    function automatic logic [FSV_DLY_W-1:0] clamp_delay(input logic [FSV_DLY_W-1:0] d);
        if (d > FSV_DLY_W'(FSV_DLY_MAX))
            return FSV_DLY_W'(FSV_DLY_MAX);
        return d;
    endfunction

endpackage

// File: rtl/fsv_pin_decode.sv
module fsv_pin_decode
    import fsv_pkg::*;
#(
    parameter int NGPI = 2
) (
    input  logic [NGPI-1:0]   gpi_n,
    input  logic [2*NGPI-1:0] cfg_mode,
    output pin_ctl_t          ctl
);

    always_comb begin
        ctl = '0;
        for (int i = 0; i < NGPI; i++) begin
            gpi_mode_e m;
            m = gpi_mode_e'(cfg_mode[2*i +: 2]);
            if (!gpi_n[i]) begin
                case (m)
                    GPI_UVDIS:  ctl.uv_mask  = 1'b1;
                    GPI_MARGIN: ctl.all_mask = 1'b1;
                    GPI_MRESET: ctl.mr_act   = 1'b1;
                    default:    ;
                endcase
            end
        end
    end

endmodule

// File: rtl/fsv_fault_log.sv
module fsv_fault_log
    import fsv_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] uv_raw,
    input  logic [NCH-1:0] ov_raw,
    input  pin_ctl_t       ctl,
    input  logic           clr_hist,
    input  logic           rearm,
    output logic [NCH-1:0] status_uv,
    output logic [NCH-1:0] status_ov,
    output logic [NCH-1:0] hist_uv,
    output logic [NCH-1:0] hist_ov,
    output logic [NCH-1:0] snap_uv,
    output logic [NCH-1:0] snap_ov,
    output logic           snap_valid
);

    logic [NCH-1:0] uv_m;
    logic [NCH-1:0] ov_m;
    logic           any_fault;
    logic           clr_all;

    assign uv_m      = (ctl.uv_mask || ctl.all_mask) ? '0 : uv_raw;
    assign ov_m      = ctl.all_mask ? '0 : ov_raw;
    assign any_fault = |{uv_m, ov_m};
    assign clr_all   = clr_hist | rearm;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_uv  <= '0;
            status_ov  <= '0;
            hist_uv    <= '0;
            hist_ov    <= '0;
            snap_uv    <= '0;
            snap_ov    <= '0;
            snap_valid <= 1'b0;
        end else begin
            status_uv <= uv_m;
            status_ov <= ov_m;
            if (clr_all) begin
                hist_uv <= '0;
                hist_ov <= '0;
            end else begin
                hist_uv <= hist_uv | uv_m;
                hist_ov <= hist_ov | ov_m;
            end
            if (rearm) begin
                snap_uv    <= '0;
                snap_ov    <= '0;
                snap_valid <= 1'b0;
            end else if (!snap_valid && any_fault) begin
                snap_uv    <= uv_m;
                snap_ov    <= ov_m;
                snap_valid <= 1'b1;
            end
        end
    end

    // R4: without a clear, no history bit ever falls
    assert_hist_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !clr_all |=> (((hist_uv & $past(hist_uv)) == $past(hist_uv)) &&
                      ((hist_ov & $past(hist_ov)) == $past(hist_ov))));

    // R5: a valid snapshot is frozen until a re-arm
    assert_snap_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (snap_valid && !rearm) |=> (snap_valid && $stable(snap_uv) && $stable(snap_ov)));

    // R6: a re-arm leaves history and snapshot empty
    assert_rearm_clears_R6: assert property (@(posedge clk) disable iff (rst)
        rearm |=> (!snap_valid && hist_uv == '0 && hist_ov == '0));

endmodule

// File: rtl/fsv_out_chan.sv
module fsv_out_chan
    import fsv_pkg::*;
#(
    parameter int NSRC = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [NSRC-1:0]      src,
    input  logic [NSRC-1:0]      map,
    input  logic                 pol,
    input  logic [FSV_DLY_W-1:0] dly_cfg,
    output logic                 drive_low
);

    logic                 req;
    logic                 act;
    logic [FSV_DLY_W-1:0] dly;
    logic [FSV_DLY_W-1:0] cnt;

    assign req = |(src & map);
    assign dly = clamp_delay(dly_cfg);

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            cnt <= '0;
            act <= 1'b0;
        end else if (!act) begin
            if (cnt >= dly)
                act <= 1'b1;
            else if (tick)
                cnt <= cnt + 1'b1;
        end
    end

    assign drive_low = act ^ pol;

    // R11: release follows a dropped request at the next edge
    assert_release_R11: assert property (@(posedge clk) disable iff (rst)
        !req |=> !act);

    // R10: assertion only ever follows a held request
    assert_rise_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(act) |-> $past(req));

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsv_pkg::*;
#(
    parameter int NCH      = 6,
    parameter int NAUX     = 2,
    parameter int NGPI     = 2,
    parameter int NOUT     = 3,
    parameter int TICK_DIV = 10000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCH-1:0]            uv_cmp,
    input  logic [NCH-1:0]            ov_cmp,
    input  logic [NAUX-1:0]           aux_cmp,
    input  logic [NGPI-1:0]           gpi_n,
    input  logic [2*NGPI-1:0]         cfg_gpi_mode,
    input  logic [NAUX-1:0]           cfg_aux_pol,
    input  logic                      cfg_mr_clear,
    input  logic                      clear_hist,
    input  logic [NOUT*(2*NCH+NAUX+1)-1:0] cfg_out_map,
    input  logic [NOUT-1:0]           cfg_out_pol,
    input  logic [NOUT*FSV_DLY_W-1:0] cfg_out_delay,
    output logic [NCH-1:0]            status_uv,
    output logic [NCH-1:0]            status_ov,
    output logic [NAUX-1:0]           aux_status,
    output logic [NCH-1:0]            hist_uv,
    output logic [NCH-1:0]            hist_ov,
    output logic [NCH-1:0]            snap_uv,
    output logic [NCH-1:0]            snap_ov,
    output logic                      snap_valid,
    output logic [NOUT-1:0]           out_drive_low
);

    localparam int NSRC = 2*NCH + NAUX + 1;

    pin_ctl_t        ctl;
    logic            rearm;
    logic            mr_q;
    logic [NAUX-1:0] aux_q;
    logic [NSRC-1:0] src;
    logic            tick;

    fsv_pin_decode #(.NGPI(NGPI)) u_dec (
        .gpi_n    (gpi_n),
        .cfg_mode (cfg_gpi_mode),
        .ctl      (ctl)
    );

    assign rearm = ctl.mr_act & cfg_mr_clear;

    fsv_fault_log #(.NCH(NCH)) u_log (
        .clk        (clk),
        .rst        (rst),
        .uv_raw     (uv_cmp),
        .ov_raw     (ov_cmp),
        .ctl        (ctl),
        .clr_hist   (clear_hist),
        .rearm      (rearm),
        .status_uv  (status_uv),
        .status_ov  (status_ov),
        .hist_uv    (hist_uv),
        .hist_ov    (hist_ov),
        .snap_uv    (snap_uv),
        .snap_ov    (snap_ov),
        .snap_valid (snap_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mr_q  <= 1'b0;
            aux_q <= '0;
        end else begin
            mr_q  <= ctl.mr_act;
            aux_q <= aux_cmp ^ cfg_aux_pol;
        end
    end

    assign aux_status = aux_q;
    assign src        = {mr_q, aux_q, status_ov, status_uv};

    generate
        if (TICK_DIV <= 1) begin : g_tick_every
            assign tick = 1'b1;
        end else begin : g_tick_div
            localparam int PW = $clog2(TICK_DIV);
            logic [PW-1:0] pcnt;
            always_ff @(posedge clk) begin
                if (rst || pcnt == PW'(TICK_DIV - 1))
                    pcnt <= '0;
                else
                    pcnt <= pcnt + 1'b1;
            end
            assign tick = (pcnt == PW'(TICK_DIV - 1));
        end
    endgenerate

    generate
        for (genvar k = 0; k < NOUT; k++) begin : g_out
            fsv_out_chan #(.NSRC(NSRC)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .tick      (tick),
                .src       (src),
                .map       (cfg_out_map[k*NSRC +: NSRC]),
                .pol       (cfg_out_pol[k]),
                .dly_cfg   (cfg_out_delay[k*FSV_DLY_W +: FSV_DLY_W]),
                .drive_low (out_drive_low[k])
            );
        end
    endgenerate

    // R3: margin hides every rail fault from the live status
    assert_margin_masks_R3: assert property (@(posedge clk) disable iff (rst)
        ctl.all_mask |=> (status_uv == '0 && status_ov == '0));

    // R2: UV disable hides undervoltage from the live status
    assert_uvdis_masks_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.uv_mask |=> (status_uv == '0));

endmodule

// File: tb/sim_fault_supervisor.sv
`timescale 1ns/1ps
module sim_fault_supervisor;

    localparam int NCH = 6, NAUX = 2, NGPI = 2, NOUT = 3, TDIV = 2;
    localparam int NSRC = 2*NCH + NAUX + 1;
    localparam int DW = 14;

    logic clk = 1'b0;
    logic rst;
    logic [NCH-1:0] uv_cmp, ov_cmp;
    logic [NAUX-1:0] aux_cmp, cfg_aux_pol;
    logic [NGPI-1:0] gpi_n;
    logic [2*NGPI-1:0] cfg_gpi_mode;
    logic cfg_mr_clear, clear_hist;
    logic [NOUT*NSRC-1:0] cfg_out_map;
    logic [NOUT-1:0] cfg_out_pol;
    logic [NOUT*DW-1:0] cfg_out_delay;
    logic [NCH-1:0] status_uv, status_ov, hist_uv, hist_ov, snap_uv, snap_ov;
    logic [NAUX-1:0] aux_status;
    logic snap_valid;
    logic [NOUT-1:0] out_drive_low;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fault_supervisor #(.NCH(NCH), .NAUX(NAUX), .NGPI(NGPI), .NOUT(NOUT), .TICK_DIV(TDIV)) u0 (
        .clk(clk), .rst(rst), .uv_cmp(uv_cmp), .ov_cmp(ov_cmp), .aux_cmp(aux_cmp),
        .gpi_n(gpi_n), .cfg_gpi_mode(cfg_gpi_mode), .cfg_aux_pol(cfg_aux_pol),
        .cfg_mr_clear(cfg_mr_clear), .clear_hist(clear_hist), .cfg_out_map(cfg_out_map),
        .cfg_out_pol(cfg_out_pol), .cfg_out_delay(cfg_out_delay),
        .status_uv(status_uv), .status_ov(status_ov), .aux_status(aux_status),
        .hist_uv(hist_uv), .hist_ov(hist_ov), .snap_uv(snap_uv), .snap_ov(snap_ov),
        .snap_valid(snap_valid), .out_drive_low(out_drive_low)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_out(input int k, input int srcbit, input logic pol, input int dly);
        cfg_out_map[k*NSRC +: NSRC] = '0;
        if (srcbit >= 0) cfg_out_map[k*NSRC + srcbit] = 1'b1;
        cfg_out_pol[k] = pol;
        cfg_out_delay[k*DW +: DW] = DW'(dly);
    endtask

    task automatic quiet();
        uv_cmp = '0; ov_cmp = '0; aux_cmp = '0; cfg_aux_pol = '0;
        gpi_n = '1; cfg_gpi_mode = '0; cfg_mr_clear = 1'b0;
        cfg_out_map = '0; cfg_out_pol = '0; cfg_out_delay = '0;
        clear_hist = 1'b1;
        step(1);
        clear_hist = 1'b0;
        step(2);
    endtask

    task automatic t_reset();
        chk("R1", "status_uv after reset", 32'(status_uv), 0);
        chk("R5", "snap_valid after reset", 32'(snap_valid), 0);
        chk("R9", "drive_low after reset", 32'(out_drive_low), 0);
    endtask

    task automatic t_status_hist_snap();
        uv_cmp = 6'b000101; ov_cmp = 6'b100000;
        step(1);
        chk("R1", "status_uv", 32'(status_uv), 32'h05);
        chk("R1", "status_ov", 32'(status_ov), 32'h20);
        chk("R5", "first snap_uv", 32'(snap_uv), 32'h05);
        chk("R5", "first snap_ov", 32'(snap_ov), 32'h20);
        chk("R5", "snap_valid", 32'(snap_valid), 1);
        uv_cmp = 6'b010000; ov_cmp = '0;
        step(1);
        chk("R5", "snap_uv kept", 32'(snap_uv), 32'h05);
        chk("R4", "hist_uv accumulates", 32'(hist_uv), 32'h15);
        uv_cmp = '0;
        step(1);
        chk("R4", "hist_ov sticky", 32'(hist_ov), 32'h20);
        clear_hist = 1'b1; uv_cmp = 6'b000001;
        step(1);
        clear_hist = 1'b0; uv_cmp = '0;
        chk("R4", "clear beats fault", 32'(hist_uv), 0);
        step(1);
        chk("R4", "hist_ov cleared", 32'(hist_ov), 0);
        chk("R5", "snap survives clear_hist", 32'(snap_valid), 1);
    endtask

    task automatic t_uvdis();
        cfg_gpi_mode = 4'b0001; gpi_n = 2'b10;
        uv_cmp = 6'b111111; ov_cmp = 6'b000011;
        step(1);
        chk("R2", "uv masked", 32'(status_uv), 0);
        chk("R2", "ov passes", 32'(status_ov), 32'h03);
        chk("R2", "hist_uv masked", 32'(hist_uv), 0);
        quiet();
    endtask

    task automatic t_margin();
        set_out(0, 0, 1'b0, 0);
        cfg_gpi_mode = 4'b1000; gpi_n = 2'b01;
        uv_cmp = 6'b111111; ov_cmp = 6'b111111;
        step(2);
        chk("R3", "status_uv masked", 32'(status_uv), 0);
        chk("R3", "status_ov masked", 32'(status_ov), 0);
        chk("R3", "hist masked", 32'({hist_uv, hist_ov}), 0);
        chk("R3", "output held off", 32'(out_drive_low[0]), 0);
        gpi_n = 2'b11;
        step(2);
        chk("R8", "uv0 source drives output 0", 32'(out_drive_low[0]), 1);
        quiet();
    endtask

    task automatic t_mode_off();
        cfg_gpi_mode = 4'b0000; gpi_n = 2'b00;
        uv_cmp = 6'b000001; ov_cmp = 6'b000010;
        step(1);
        chk("R12", "mode 0 no uv mask", 32'(status_uv), 32'h01);
        chk("R12", "mode 0 no ov mask", 32'(hist_ov), 32'h02);
        quiet();
    endtask

    task automatic t_mreset();
        uv_cmp = 6'b000010;
        step(1);
        uv_cmp = '0;
        set_out(2, 14, 1'b0, 0);
        cfg_gpi_mode = 4'b0011; gpi_n = 2'b10; cfg_mr_clear = 1'b0;
        step(2);
        chk("R6", "no clear when disabled: hist", 32'(hist_uv), 32'h02);
        chk("R6", "no clear when disabled: snap", 32'(snap_valid), 1);
        chk("R8", "manual reset source on output 2", 32'(out_drive_low[2]), 1);
        cfg_mr_clear = 1'b1; uv_cmp = 6'b000100;
        step(1);
        chk("R6", "hist cleared", 32'(hist_uv), 0);
        chk("R6", "snapshot re-armed", 32'(snap_valid), 0);
        gpi_n = 2'b11; uv_cmp = 6'b001000;
        step(1);
        chk("R5", "recapture after re-arm", 32'(snap_uv), 32'h08);
        chk("R5", "valid after recapture", 32'(snap_valid), 1);
        quiet();
    endtask

    task automatic t_aux();
        set_out(1, 12, 1'b0, 0);
        cfg_aux_pol = 2'b10; aux_cmp = 2'b00;
        step(1);
        chk("R7", "aux inverted", 32'(aux_status), 32'h2);
        aux_cmp = 2'b11;
        step(1);
        chk("R7", "aux both high", 32'(aux_status), 32'h1);
        step(1);
        chk("R8", "aux0 source on output 1", 32'(out_drive_low[1]), 1);
        quiet();
    endtask

    task automatic t_polarity();
        set_out(0, 5, 1'b1, 0);
        step(1);
        chk("R9", "inverted idle drives low", 32'(out_drive_low[0]), 1);
        uv_cmp = 6'b100000;
        step(2);
        chk("R9", "inverted asserted releases", 32'(out_drive_low[0]), 0);
        quiet();
    endtask

    task automatic t_delay();
        set_out(0, 3, 1'b0, 10);
        uv_cmp = 6'b001000;
        step(16);
        chk("R10", "not yet asserted", 32'(out_drive_low[0]), 0);
        step(10);
        chk("R10", "asserted after delay", 32'(out_drive_low[0]), 1);
        uv_cmp = '0;
        step(2);
        chk("R11", "immediate release", 32'(out_drive_low[0]), 0);
        set_out(0, 3, 1'b0, 16383);
        uv_cmp = 6'b001000;
        step(31990);
        chk("R10", "clamped delay not yet", 32'(out_drive_low[0]), 0);
        step(20);
        chk("R10", "clamped to 16000 ticks", 32'(out_drive_low[0]), 1);
        uv_cmp = '0;
        step(2);
        chk("R11", "release after long delay", 32'(out_drive_low[0]), 0);
        quiet();
    endtask

    initial begin
        rst = 1'b1;
        uv_cmp = '0; ov_cmp = '0; aux_cmp = '0; cfg_aux_pol = '0;
        gpi_n = '1; cfg_gpi_mode = '0; cfg_mr_clear = 1'b0; clear_hist = 1'b0;
        cfg_out_map = '0; cfg_out_pol = '0; cfg_out_delay = '0;
        step(4);
        rst = 1'b0;
        step(1);
        t_reset();
        t_status_hist_snap();
        quiet();
        t_uvdis();
        t_margin();
        t_mode_off();
        t_mreset();
        t_aux();
        t_polarity();
        t_delay();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule